// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data buses, called A and B, inside a synchronous design. Each bus is carried on three separate signals (incoming data, outgoing data and a drive enable) instead of a tri-state net. The block is split into independent slices of `WIDTH` bits. With the default of two 8-bit slices it forms a 16-bit path, and each slice keeps its own controls.

Every slice holds two capture registers. The A-side register takes the A bus value when its capture strobe rises. The B-side register does the same for the B bus with its own strobe. Capture runs whatever state the outputs are in. An active-low output enable and a direction input pick which bus the slice drives, if any. Per-direction select inputs choose, for the driven bus, between live data passed through from the other bus and the value held in that direction's register.

The capture strobes are ordinary inputs in the `clk` domain. A rise is found by comparing each strobe with its value at the previous edge. The routing path holds no registers, so a change of direction, enable or select shows on the outputs in the same cycle.

Top module: `xcvr_bus_pair`

## Requirements
- R1: When `cap_ab[s]` is sampled high at a `clk` edge after being sampled low at the edge before, the A-side register of slice s loads the slice's `a_in` bits at that edge.
- R2: When `cap_ba[s]` is sampled high at a `clk` edge after being sampled low at the edge before, the B-side register of slice s loads the slice's `b_in` bits at that edge.
- R3: A strobe held high for several edges loads its register only at the first of them. While there is no rising strobe, a register keeps its value even when its bus input changes.
- R4: While `oe_n[s]` is 1 (isolation), `a_oe[s]` and `b_oe[s]` are both 0.
- R5: Capture does not depend on `oe_n`, `dir` or the selects. Both registers of a slice may load at the same edge, and they may load during isolation.
- R6: While `oe_n[s]` is 0, `dir[s]`=0 sets `a_oe[s]`=1 and `b_oe[s]`=0, and `dir[s]`=1 sets `b_oe[s]`=1 and `a_oe[s]`=0. The two enables of a slice are never both 1.
- R7: While A is driven, `sel_ba[s]`=0 puts the slice's live `b_in` bits on `a_out`, and `sel_ba[s]`=1 puts the B-side register there, in the same cycle.
- R8: While B is driven, `sel_ab[s]`=0 puts the slice's live `a_in` bits on `b_out`, and `sel_ab[s]`=1 puts the A-side register there, in the same cycle.
- R9: The outgoing data of a bus whose enable is 0 reads all zeros.
- R10: While `rst_n` is low, both registers of every slice clear to zero, so stored-data routing returns zero until the first capture.
- R11: Slice s uses bits [s*WIDTH +: WIDTH] of each data vector and bit s of each control vector. Its controls and strobes never change another slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for capture and strobe sampling |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| oe_n | input | NSLICE | Active-low output enable, one per slice |
| dir | input | NSLICE | Direction per slice: 0 drives A, 1 drives B |
| cap_ab | input | NSLICE | A-side capture strobe per slice (rising edge loads) |
| cap_ba | input | NSLICE | B-side capture strobe per slice (rising edge loads) |
| sel_ab | input | NSLICE | Source for B: 0 live A, 1 stored A |
| sel_ba | input | NSLICE | Source for A: 0 live B, 1 stored B |
| a_in | input | NSLICE*WIDTH | Incoming A bus data |
| a_out | output | NSLICE*WIDTH | Outgoing A bus data |
| a_oe | output | NSLICE | A bus drive enable per slice |
| b_in | input | NSLICE*WIDTH | Incoming B bus data |
| b_out | output | NSLICE*WIDTH | Outgoing B bus data |
| b_oe | output | NSLICE | B bus drive enable per slice |

## Verification
The capture properties assume that both strobes are low while reset is asserted. If they are not, the first sampled rise after release does not match the strobe history the design kept. The assumption also requires strobes and bus inputs to change only between clock edges. The stimulus meets both conditions: it holds every strobe at zero through reset, and it changes inputs only one nanosecond after a rising edge, well before the next edge samples them.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Source chosen for the driven bus of one direction
  typedef enum logic {
    ROUTE_LIVE   = 1'b0,
    ROUTE_STORED = 1'b1
  } route_e;

  // Which bus of a slice is driven
  typedef struct packed {
    logic a_en;
    logic b_en;
  } drive_t;

  // Decode of the active-low enable and direction into bus drives
  function automatic drive_t decode_drive(input logic oe_n, input logic dir);
    drive_t d;
    d.a_en = ~oe_n & ~dir;
    d.b_en = ~oe_n &  dir;
    return d;
  endfunction

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);

  logic             strobe_q;
  logic             load_en;
  logic [WIDTH-1:0] q_nxt;

  // rising strobe seen at this edge
  assign load_en = strobe & ~strobe_q;

  always_comb begin
    q_nxt = q;
    if (load_en) begin
      q_nxt = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      q        <= '0;
    end else begin
      strobe_q <= strobe;
      q        <= q_nxt;
    end
  end

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_live,
  input  logic [WIDTH-1:0] b_live,
  input  logic [WIDTH-1:0] a_store,
  input  logic [WIDTH-1:0] b_store,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  drive_t           drv;
  route_e           src_to_a;
  route_e           src_to_b;
  logic [WIDTH-1:0] mux_to_a;
  logic [WIDTH-1:0] mux_to_b;

  assign drv      = decode_drive(oe_n, dir);
  assign src_to_a = route_e'(sel_ba);
  assign src_to_b = route_e'(sel_ab);

  // AND-OR mux with the consensus term: when live and stored bits agree,
  // the bit stays asserted across a select change.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign mux_to_a[i] = ((src_to_a == ROUTE_STORED) & b_store[i])
                       | ((src_to_a == ROUTE_LIVE)   & b_live[i])
                       | (b_store[i] & b_live[i]);
    assign mux_to_b[i] = ((src_to_b == ROUTE_STORED) & a_store[i])
                       | ((src_to_b == ROUTE_LIVE)   & a_live[i])
                       | (a_store[i] & a_live[i]);
  end

  assign a_oe  = drv.a_en;
  assign b_oe  = drv.b_en;
  assign a_out = mux_to_a & {WIDTH{drv.a_en}};
  assign b_out = mux_to_b & {WIDTH{drv.b_en}};

endmodule

// File: rtl/xcvr_slice.sv
module xcvr_slice #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             cap_ab,
  input  logic             cap_ba,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  output logic [WIDTH-1:0] store_a,
  output logic [WIDTH-1:0] store_b
);

  xcvr_capture #(.WIDTH(WIDTH)) u_cap_a (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cap_ab),
    .din    (a_in),
    .q      (store_a)
  );

  xcvr_capture #(.WIDTH(WIDTH)) u_cap_b (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cap_ba),
    .din    (b_in),
    .q      (store_b)
  );

  xcvr_route #(.WIDTH(WIDTH)) u_route (
    .oe_n    (oe_n),
    .dir     (dir),
    .sel_ab  (sel_ab),
    .sel_ba  (sel_ba),
    .a_live  (a_in),
    .b_live  (b_in),
    .a_store (store_a),
    .b_store (store_b),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_out   (b_out),
    .b_oe    (b_oe)
  );

endmodule

// File: rtl/xcvr_bus_pair.sv
module xcvr_bus_pair #(
  parameter int NSLICE = 2,
  parameter int WIDTH  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSLICE-1:0]       oe_n,
  input  logic [NSLICE-1:0]       dir,
  input  logic [NSLICE-1:0]       cap_ab,
  input  logic [NSLICE-1:0]       cap_ba,
  input  logic [NSLICE-1:0]       sel_ab,
  input  logic [NSLICE-1:0]       sel_ba,
  input  logic [NSLICE*WIDTH-1:0] a_in,
  output logic [NSLICE*WIDTH-1:0] a_out,
  output logic [NSLICE-1:0]       a_oe,
  input  logic [NSLICE*WIDTH-1:0] b_in,
  output logic [NSLICE*WIDTH-1:0] b_out,
  output logic [NSLICE-1:0]       b_oe
);

  localparam int BUS_W = NSLICE * WIDTH;

  logic [BUS_W-1:0] store_a_q;
  logic [BUS_W-1:0] store_b_q;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    xcvr_slice #(.WIDTH(WIDTH)) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .oe_n    (oe_n[s]),
      .dir     (dir[s]),
      .cap_ab  (cap_ab[s]),
      .cap_ba  (cap_ba[s]),
      .sel_ab  (sel_ab[s]),
      .sel_ba  (sel_ba[s]),
      .a_in    (a_in[s*WIDTH +: WIDTH]),
      .b_in    (b_in[s*WIDTH +: WIDTH]),
      .a_out   (a_out[s*WIDTH +: WIDTH]),
      .a_oe    (a_oe[s]),
      .b_out   (b_out[s*WIDTH +: WIDTH]),
      .b_oe    (b_oe[s]),
      .store_a (store_a_q[s*WIDTH +: WIDTH]),
      .store_b (store_b_q[s*WIDTH +: WIDTH])
    );
  end

endmodule

// File: rtl/xcvr_bus_pair_chk.sv
module xcvr_bus_pair_chk #(
  parameter int NSLICE = 2,
  parameter int WIDTH  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NSLICE-1:0]       oe_n,
  input logic [NSLICE-1:0]       cap_ab,
  input logic [NSLICE-1:0]       cap_ba,
  input logic [NSLICE-1:0]       sel_ab,
  input logic [NSLICE-1:0]       sel_ba,
  input logic [NSLICE*WIDTH-1:0] a_in,
  input logic [NSLICE*WIDTH-1:0] a_out,
  input logic [NSLICE-1:0]       a_oe,
  input logic [NSLICE*WIDTH-1:0] b_in,
  input logic [NSLICE*WIDTH-1:0] b_out,
  input logic [NSLICE-1:0]       b_oe,
  input logic [NSLICE*WIDTH-1:0] store_a_q,
  input logic [NSLICE*WIDTH-1:0] store_b_q
);

  for (genvar s = 0; s < NSLICE; s++) begin : g_chk
    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_oe[s] && b_oe[s])); // R6

    AST_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n[s] |-> (!a_oe[s] && !b_oe[s])); // R4

    AST_CAP_A_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_ab[s]) |=> store_a_q[s*WIDTH +: WIDTH] == $past(a_in[s*WIDTH +: WIDTH])); // R1

    AST_CAP_B_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_ba[s]) |=> store_b_q[s*WIDTH +: WIDTH] == $past(b_in[s*WIDTH +: WIDTH])); // R2

    AST_CAP_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(cap_ab[s]) |=> $stable(store_a_q[s*WIDTH +: WIDTH])); // R3

    AST_CAP_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(cap_ba[s]) |=> $stable(store_b_q[s*WIDTH +: WIDTH])); // R3

    AST_LIVE_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
      (a_oe[s] && !sel_ba[s]) |-> a_out[s*WIDTH +: WIDTH] == b_in[s*WIDTH +: WIDTH]); // R7

    AST_STORED_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
      (b_oe[s] && sel_ab[s]) |-> b_out[s*WIDTH +: WIDTH] == store_a_q[s*WIDTH +: WIDTH]); // R8

    AST_IDLE_A_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !a_oe[s] |-> a_out[s*WIDTH +: WIDTH] == '0); // R9

    AST_IDLE_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !b_oe[s] |-> b_out[s*WIDTH +: WIDTH] == '0); // R9
  end

endmodule

bind xcvr_bus_pair xcvr_bus_pair_chk #(.NSLICE(NSLICE), .WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .oe_n      (oe_n),
  .cap_ab    (cap_ab),
  .cap_ba    (cap_ba),
  .sel_ab    (sel_ab),
  .sel_ba    (sel_ba),
  .a_in      (a_in),
  .a_out     (a_out),
  .a_oe      (a_oe),
  .b_in      (b_in),
  .b_out     (b_out),
  .b_oe      (b_oe),
  .store_a_q (store_a_q),
  .store_b_q (store_b_q)
);

// File: tb/xcvr_bus_pair_tb.sv
`timescale 1ns/1ps
module xcvr_bus_pair_tb;

  localparam int NS = 2;
  localparam int W  = 8;

  logic            clk;
  logic            rst_n;
  logic [NS-1:0]   oe_n, dir, cap_ab, cap_ba, sel_ab, sel_ba;
  logic [NS*W-1:0] a_in, b_in, a_out, b_out;
  logic [NS-1:0]   a_oe, b_oe;

  xcvr_bus_pair #(.NSLICE(NS), .WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    string           tag;
    logic [NS*W-1:0] a_out;
    logic [NS*W-1:0] b_out;
    logic [NS-1:0]   a_oe;
    logic [NS-1:0]   b_oe;
  } item_t;

  item_t           sb_q[$];
  int              n_checks = 0;
  int              n_errors = 0;
  bit              done     = 1'b0;
  logic [W-1:0]    m_a [NS];
  logic [W-1:0]    m_b [NS];
  logic [NS-1:0]   m_pab, m_pba;

  // Driver: inputs are already applied; predict outputs, queue them,
  // then advance the register model across the coming edge.
  task automatic cycle(input string tag);
    item_t it;
    it.tag = tag;
    for (int s = 0; s < NS; s++) begin
      logic ea, eb;
      ea = !oe_n[s] && !dir[s];
      eb = !oe_n[s] &&  dir[s];
      it.a_oe[s] = ea;
      it.b_oe[s] = eb;
      it.a_out[s*W +: W] = !ea ? '0 : (sel_ba[s] ? m_b[s] : b_in[s*W +: W]);
      it.b_out[s*W +: W] = !eb ? '0 : (sel_ab[s] ? m_a[s] : a_in[s*W +: W]);
    end
    sb_q.push_back(it);
    for (int s = 0; s < NS; s++) begin
      if (cap_ab[s] && !m_pab[s]) m_a[s] = a_in[s*W +: W];
      if (cap_ba[s] && !m_pba[s]) m_b[s] = b_in[s*W +: W];
    end
    m_pab = cap_ab;
    m_pba = cap_ba;
    @(posedge clk);
    #1;
  endtask

  // Monitor: compares at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_checks++;
      if (a_out !== it.a_out || b_out !== it.b_out ||
          a_oe !== it.a_oe || b_oe !== it.b_oe) begin
        n_errors++;
        $display("FAIL %s: a_out=%h b_out=%h a_oe=%b b_oe=%b expected a_out=%h b_out=%h a_oe=%b b_oe=%b",
                 it.tag, a_out, b_out, a_oe, b_oe, it.a_out, it.b_out, it.a_oe, it.b_oe);
      end
    end
  end

  initial begin
    #150000;
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    oe_n = '1; dir = '0; cap_ab = '0; cap_ba = '0; sel_ab = '0; sel_ba = '0;
    a_in = 16'hA5C3; b_in = 16'h3CF0;
    for (int s = 0; s < NS; s++) begin m_a[s] = '0; m_b[s] = '0; end
    m_pab = '0; m_pba = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R10: stored routing returns zero after reset
    oe_n = 2'b00; dir = 2'b10; sel_ba = 2'b11; sel_ab = 2'b11;
    cycle("R10 stored values cleared");

    // R7 and R8 live pass-through; R6 enables per direction
    sel_ba = 2'b00; sel_ab = 2'b00; b_in = 16'h005A; a_in = 16'h3C00;
    cycle("R7 R8 R6 live transfer");

    // R4 isolation with R5 capture of both ports in both slices
    oe_n = 2'b11; a_in = 16'h1122; b_in = 16'h3344; cap_ab = 2'b11; cap_ba = 2'b11;
    cycle("R4 R5 isolation capture");

    // R3: strobes stay high, inputs change, no reload
    oe_n = 2'b00; a_in = 16'hFFFF; b_in = 16'hEEEE; sel_ba = 2'b11; sel_ab = 2'b11;
    cycle("R3 held strobe no reload");
    cap_ab = 2'b00; cap_ba = 2'b00;
    cycle("R5 R7 R8 stored after isolation");

    // R1: slice 0 A capture only; R11 slice 1 untouched
    a_in = 16'h5577; cap_ab = 2'b01;
    cycle("R1 A capture edge");
    cap_ab = 2'b00; dir = 2'b11; a_in = 16'h0000;
    cycle("R1 R11 A stored to B");

    // R8: switch slice 0 select to live in one cycle
    sel_ab = 2'b10; a_in = 16'h00C8;
    cycle("R8 select switch live");

    // R2: slice 1 B capture; R11 slice 0 B register unchanged
    b_in = 16'h9912; cap_ba = 2'b10;
    cycle("R2 B capture edge");
    cap_ba = 2'b00; dir = 2'b00; b_in = 16'h0000; sel_ba = 2'b11;
    cycle("R2 R11 B stored to A");

    // R9: undriven side reads zero for every direction
    dir = 2'b01; a_in = 16'hFFFF; b_in = 16'hFFFF;
    cycle("R9 idle bus zero");

    // Mixed patterns across all controls
    for (int k = 0; k < 24; k++) begin
      oe_n   = 2'(k >> 3) & 2'(k);
      dir    = 2'(k * 3);
      sel_ab = 2'(k >> 1);
      sel_ba = 2'(k >> 2);
      cap_ab = 2'(k * 5);
      cap_ba = 2'(k * 7 + 1);
      a_in   = 16'(k * 16'h1D37 + 16'h0101);
      b_in   = 16'(k * 16'h2B59 + 16'h8080);
      cycle("R1 R2 R6 R7 R8 mixed");
    end

    // R10: reset clears both registers again
    rst_n = 1'b0;
    cap_ab = '0; cap_ba = '0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int s = 0; s < NS; s++) begin m_a[s] = '0; m_b[s] = '0; end
    m_pab = '0; m_pba = '0;
    oe_n = 2'b00; dir = 2'b10; sel_ab = 2'b11; sel_ba = 2'b11;
    cycle("R10 reset clears stored");
    dir = 2'b01;
    cycle("R10 reset clears stored other side");

    @(negedge clk); #1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule